// File: doc/BRIEF.md
# Tile Map Source Selector

This block sits between a video renderer and the storage behind its background tile map. The renderer's tile-map space is four 1 KiB quadrants. A CPU-written mapping register sends each quadrant to one of four sources: internal page A, internal page B, a 1 KiB extension RAM held inside the block, or a fill generator that returns a constant tile number and a constant attribute byte. The two internal pages live outside the block. They are reached through a simple page port that returns read data one cycle after it is enabled.

An extended-attribute mode changes how the extension RAM is used. The block remembers the offset of the most recent tile-number read. The extension RAM byte at that offset then supplies the palette bits for the next attribute fetch, placed in the bit pair the renderer expects. The same byte supplies a 4 KiB pattern bank for background pattern fetches, which the block reports as a full pattern address. The CPU also reaches the extension RAM directly through a byte window whose behaviour depends on the mode.

Renderer reads use a valid/ready request channel and a valid/ready response channel. A read is accepted when `req_valid` and `req_ready` are both high at a clock edge. Its response appears on the next cycle and stays unchanged until `rsp_ready` takes it. While a response waits, `req_ready` is low, so back-pressure on the response stalls the request side. Renderer writes use the same request channel but produce no response.

Top module: `tilemap_router`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. All configuration registers are 0: mode 0, every quadrant on page A, fill tile 0, fill attribute 0, high bank 0.
- R2: For a tile-map request (`req_addr[13]`=1), bits 11:10 pick the quadrant and bits 9:0 are the offset. Quadrant q uses field bits 2q+1:2q of the mapping register (`cfg_sel`=1). Code 0 is page A and code 1 is page B. For these codes the block enables the page port with `page_addr` = {code bit 0, offset} and returns `page_rdata` as the response.
- R3: Code 3 (fill) returns the fill tile (`cfg_sel`=2) for offsets below 0x3C0. Offsets at or above 0x3C0 return the fill attribute byte. Bits 1:0 of a fill attribute write (`cfg_sel`=3) are copied into all four bit pairs of that byte.
- R4: Code 2 returns the extension RAM byte at the offset when the mode (`cfg_sel`=0, bits 1:0) is 0 or 1. It returns 0 when the mode is 2 or 3.
- R5: In mode 1, a tile-map read at offset 0x3C0 or above, in any quadrant, returns (E[7:6] << s) & 0xFF. E is the extension RAM byte at the latched index L. s = 2 × (2 × bit 1 of (L div 32) + bit 1 of (L mod 32)).
- R6: In mode 1, a pattern read (`req_addr[13]`=0) with `req_bg`=1 returns `rsp_pat_ovr`=1 and `rsp_pat_addr` = {H, E[5:0], `req_addr[11:0]`}. H is the high bank register (`cfg_sel`=4, bits 1:0) and E is the byte at L.
- R7: Any other pattern read returns `rsp_pat_ovr`=0, `rsp_data`=0, and `rsp_pat_addr` = `req_addr[12:0]` zero-extended.
- R8: A renderer write to a tile-map quadrant goes to the page port for codes 0 and 1 and to the extension RAM for code 2, whatever the mode. For code 3 it is discarded. No renderer write produces a response.
- R9: CPU window: a write (`xw_we`) is ignored in mode 3. A read (`xw_re`) returns data on `xw_rdata` the next cycle: 0xFF if the mode was below 2 when the read was issued, otherwise the stored byte.
- R10: `req_ready` is high exactly when there is no response, or the response is being taken. A response appears the cycle after its request and holds its values until it is taken. No response appears without a read request.
- R11: Only tile-map reads below offset 0x3C0 update the latched index L. Attribute reads, pattern reads and all writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Renderer request valid |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 14 | Renderer address; bit 13 set means tile-map space |
| req_we | input | 1 | Request is a write |
| req_wdata | input | 8 | Write data |
| req_bg | input | 1 | Fetch phase: 1 background, 0 sprite |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Renderer takes the response |
| rsp_data | output | 8 | Read data |
| rsp_pat_ovr | output | 1 | Pattern address override is active |
| rsp_pat_addr | output | 20 | Pattern address |
| page_en | output | 1 | Internal page access |
| page_we | output | 1 | Internal page write |
| page_addr | output | 11 | Page select and offset |
| page_wdata | output | 8 | Internal page write data |
| page_rdata | input | 8 | Internal page read data, one cycle after enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 mode, 1 mapping, 2 fill tile, 3 fill attribute, 4 high bank |
| cfg_wdata | input | 8 | Configuration write data |
| xw_we | input | 1 | CPU extension RAM write |
| xw_re | input | 1 | CPU extension RAM read |
| xw_addr | input | 10 | CPU extension RAM address |
| xw_wdata | input | 8 | CPU write data |
| xw_rdata | output | 8 | CPU read data |

## Verification
The assertions assume that `page_rdata` changes only in the cycle after `page_en`, as a synchronous RAM's output does. The stimulus meets this with a page model that updates its output only on an enabled read. They also assume that the renderer raises no request while a response is still waiting. The stimulus drives one request at a time and holds `rsp_ready` low for random stretches before taking each response. A CPU write and a renderer write to the same extension RAM byte in the same cycle is never issued, so the order between the two writers is left unchecked.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_PAGE_A = 2'd0,
    SRC_PAGE_B = 2'd1,
    SRC_XRAM   = 2'd2,
    SRC_FILL   = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    K_PAGE  = 3'd0,
    K_XTILE = 3'd1,
    K_ZERO  = 3'd2,
    K_FILL  = 3'd3,
    K_ATTR  = 3'd4,
    K_PATX  = 3'd5,
    K_PATN  = 3'd6
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [7:0]  lit;
    logic [2:0]  sh;
    logic [12:0] low;
  } rsp_ctl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [1:0]    xmode,
  output logic [7:0]    qmap,
  output logic [DW-1:0] fill_tile,
  output logic [DW-1:0] fill_attr,
  output logic [1:0]    hi_bank
);
  localparam int PAIRS = DW / 2;
  logic [1:0] attr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xmode <= '0; qmap <= '0; fill_tile <= '0; attr_q <= '0; hi_bank <= '0;
    end else if (we) begin
      case (sel)
        3'd0: xmode     <= wdata[1:0];
        3'd1: qmap      <= wdata[7:0];
        3'd2: fill_tile <= wdata;
        3'd3: attr_q    <= wdata[1:0];
        3'd4: hi_bank   <= wdata[1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < PAIRS; i++) begin : g_rep
    assign fill_attr[2*i +: 2] = attr_q;
  end
endmodule

// File: rtl/tmr_xram.sv
module tmr_xram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_rd,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          c_we,
  input  logic          c_re,
  input  logic [AW-1:0] c_addr,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] c_rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (c_we) mem[c_addr] <= c_wdata;
    if (a_wr) mem[a_addr] <= a_wdata;
    if (a_rd) a_rdata <= mem[a_addr];
    if (c_re) c_rdata <= mem[c_addr];
  end
endmodule

// File: rtl/tmr_route.sv
module tmr_route
  import tmr_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int DW    = 8
) (
  input  logic [13:0]      addr,
  input  logic             we,
  input  logic             bg,
  input  logic [1:0]       xmode,
  input  logic [7:0]       qmap,
  input  logic [DW-1:0]    fill_tile,
  input  logic [DW-1:0]    fill_attr,
  input  logic [1:0]       hi_bank,
  input  logic [OFS_W-1:0] tidx,
  output rsp_ctl_t         ctl,
  output logic             page_hit,
  output logic             page_b,
  output logic             x_rd,
  output logic             x_wr,
  output logic [OFS_W-1:0] x_addr,
  output logic             latch
);
  localparam int QSIZE     = 1 << OFS_W;
  localparam int ATTR_BASE = QSIZE - QSIZE / 16;

  logic [OFS_W-1:0] ofs;
  logic [1:0]       q;
  src_e             src;
  logic             is_map, is_attr;

  assign ofs     = addr[OFS_W-1:0];
  assign q       = addr[11:10];
  assign src     = src_e'(qmap[2*q +: 2]);
  assign is_map  = addr[13];
  assign is_attr = (int'(ofs) >= ATTR_BASE);

  always_comb begin
    ctl      = '{kind: K_PATN, lit: '0, sh: '0, low: addr[12:0]};
    page_hit = 1'b0;
    page_b   = 1'b0;
    x_rd     = 1'b0;
    x_wr     = 1'b0;
    x_addr   = '0;
    latch    = 1'b0;
    if (is_map) begin
      latch = !we && !is_attr;
      if (!we && is_attr && xmode == 2'd1) begin
        ctl.kind = K_ATTR;
        ctl.sh   = {tidx[6], tidx[1], 1'b0};
        x_rd     = 1'b1;
        x_addr   = tidx;
      end else begin
        case (src)
          SRC_PAGE_A, SRC_PAGE_B: begin
            ctl.kind = K_PAGE;
            page_hit = 1'b1;
            page_b   = (src == SRC_PAGE_B);
          end
          SRC_XRAM: begin
            x_addr = ofs;
            if (we) x_wr = 1'b1;
            else if (xmode[1]) ctl.kind = K_ZERO;
            else begin
              ctl.kind = K_XTILE;
              x_rd     = 1'b1;
            end
          end
          default: begin
            ctl.kind = K_FILL;
            ctl.lit  = is_attr ? fill_attr : fill_tile;
          end
        endcase
      end
    end else if (!we && bg && xmode == 2'd1) begin
      ctl.kind = K_PATX;
      ctl.lit  = {6'b0, hi_bank};
      x_rd     = 1'b1;
      x_addr   = tidx;
    end
  end
endmodule

// File: rtl/tilemap_router.sv
module tilemap_router
  import tmr_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [13:0]      req_addr,
  input  logic             req_we,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_bg,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_data,
  output logic             rsp_pat_ovr,
  output logic [19:0]      rsp_pat_addr,
  output logic             page_en,
  output logic             page_we,
  output logic [OFS_W:0]   page_addr,
  output logic [DW-1:0]    page_wdata,
  input  logic [DW-1:0]    page_rdata,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             xw_we,
  input  logic             xw_re,
  input  logic [OFS_W-1:0] xw_addr,
  input  logic [DW-1:0]    xw_wdata,
  output logic [DW-1:0]    xw_rdata
);
  localparam int PAT_LOW = 12;

  logic [1:0]       xmode, hi_bank;
  logic [7:0]       qmap;
  logic [DW-1:0]    fill_tile, fill_attr, x_rdata, c_raw;
  logic [OFS_W-1:0] tidx, x_addr;
  rsp_ctl_t         ctl, ctl_q;
  logic             page_hit, page_b, x_rd, x_wr, latch, accept, cpu_mask;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  tmr_regs #(.DW(DW)) u_regs (
    .clk, .rst_n, .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .xmode, .qmap, .fill_tile, .fill_attr, .hi_bank
  );

  tmr_route #(.OFS_W(OFS_W), .DW(DW)) u_route (
    .addr(req_addr), .we(req_we), .bg(req_bg), .xmode, .qmap,
    .fill_tile, .fill_attr, .hi_bank, .tidx, .ctl,
    .page_hit, .page_b, .x_rd, .x_wr, .x_addr, .latch
  );

  tmr_xram #(.AW(OFS_W), .DW(DW)) u_xram (
    .clk,
    .a_rd(accept && x_rd), .a_wr(accept && x_wr), .a_addr(x_addr),
    .a_wdata(req_wdata), .a_rdata(x_rdata),
    .c_we(xw_we && xmode != 2'd3), .c_re(xw_re), .c_addr(xw_addr),
    .c_wdata(xw_wdata), .c_rdata(c_raw)
  );

  assign page_en    = accept && page_hit;
  assign page_we    = req_we;
  assign page_addr  = {page_b, req_addr[OFS_W-1:0]};
  assign page_wdata = req_wdata;
  assign xw_rdata   = cpu_mask ? '1 : c_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      ctl_q     <= '{kind: K_PATN, lit: '0, sh: '0, low: '0};
      tidx      <= '0;
      cpu_mask  <= 1'b1;
    end else begin
      if (accept) begin
        rsp_valid <= !req_we;
        if (!req_we) ctl_q <= ctl;
        if (latch) tidx <= req_addr[OFS_W-1:0];
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (xw_re) cpu_mask <= !xmode[1];
    end
  end

  always_comb begin
    rsp_data     = '0;
    rsp_pat_ovr  = 1'b0;
    rsp_pat_addr = {7'b0, ctl_q.low};
    case (ctl_q.kind)
      K_PAGE:  rsp_data = page_rdata;
      K_XTILE: rsp_data = x_rdata;
      K_FILL:  rsp_data = ctl_q.lit;
      K_ATTR:  rsp_data = {6'b0, x_rdata[7:6]} << ctl_q.sh;
      K_PATX: begin
        rsp_pat_ovr  = 1'b1;
        rsp_pat_addr = {ctl_q.lit[1:0], x_rdata[5:0], ctl_q.low[PAT_LOW-1:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_data,
  input logic [19:0] rsp_pat_addr,
  input logic        page_en,
  input logic        xw_re,
  input logic [7:0]  xw_rdata,
  input logic [1:0]  xmode,
  input kind_e       rsp_kind
);
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_pat_addr));

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid && !req_valid |=> !rsp_valid);

  assert_page_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    page_en |-> req_valid && req_ready);

  assert_cpu_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(xw_re) && !$past(xmode[1]) |-> xw_rdata == 8'hFF);

  assert_attr_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_kind == K_ATTR |-> $countones(rsp_data) <= 2);
endmodule

bind tilemap_router tmr_checker u_chk (
  .clk, .rst_n, .req_valid, .req_ready, .rsp_valid, .rsp_ready,
  .rsp_data, .rsp_pat_addr, .page_en, .xw_re, .xw_rdata, .xmode,
  .rsp_kind(ctl_q.kind)
);

// File: tb/tilemap_router_test.sv
`timescale 1ns/1ps
module tilemap_router_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, req_bg = 0, rsp_ready = 0;
  logic [13:0] req_addr = 0;
  logic [7:0] req_wdata = 0, page_rdata = 0, cfg_wdata = 0, xw_wdata = 0;
  logic cfg_we = 0, xw_we = 0, xw_re = 0;
  logic [2:0] cfg_sel = 0;
  logic [9:0] xw_addr = 0;
  logic req_ready, rsp_valid, rsp_pat_ovr, page_en, page_we;
  logic [7:0] rsp_data, page_wdata, xw_rdata;
  logic [19:0] rsp_pat_addr;
  logic [10:0] page_addr;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] pg [2048];
  logic [7:0] exp_pg [2048];
  logic [7:0] xr [1024];
  int m_mode = 0, m_map = 0, m_tile = 0, m_attr = 0, m_hi = 0, m_tidx = 0;

  always #2.5 clk = ~clk;

  tilemap_router uut (.*);

  always @(posedge clk) if (page_en) begin
    if (page_we) pg[page_addr] <= page_wdata;
    else page_rdata <= pg[page_addr];
  end

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(int sel, int val);
    @(negedge clk); cfg_we = 1; cfg_sel = sel[2:0]; cfg_wdata = val[7:0];
    @(negedge clk); cfg_we = 0;
    case (sel)
      0: m_mode = val & 3;
      1: m_map = val & 255;
      2: m_tile = val & 255;
      3: m_attr = (val & 3) * 8'h55;
      4: m_hi = val & 3;
      default: ;
    endcase
  endtask

  task automatic cpu_wr(int a, int v);
    @(negedge clk); xw_we = 1; xw_addr = a[9:0]; xw_wdata = v[7:0];
    @(negedge clk); xw_we = 0;
    if (m_mode != 3) xr[a] = v[7:0];
  endtask

  task automatic cpu_rd(int a);
    int e;
    @(negedge clk); xw_re = 1; xw_addr = a[9:0];
    @(negedge clk); xw_re = 0;
    e = (m_mode < 2) ? 8'hFF : xr[a];
    chk(xw_rdata == e[7:0], "R9 cpu window read", xw_rdata, e);
  endtask

  function automatic int src_of(int addr);
    return (m_map >> (2 * ((addr >> 10) & 3))) & 3;
  endfunction

  task automatic ren_wr(int addr, int v);
    int s = src_of(addr), o = addr & 1023;
    @(negedge clk); req_valid = 1; req_we = 1; req_addr = addr[13:0]; req_wdata = v[7:0];
    @(negedge clk); req_valid = 0; req_we = 0;
    chk(rsp_valid == 0, "R8 write gives no response", rsp_valid, 0);
    if (addr >= 'h2000) begin
      if (s < 2) exp_pg[s * 1024 + o] = v[7:0];
      else if (s == 2) xr[o] = v[7:0];
    end
  endtask

  task automatic ren_rd(int addr, bit bg, int stall);
    int o = addr & 1023, s = src_of(addr), ed = 0, eo = 0, ea, e, sh, tx, ty;
    string rq = "R7 plain pattern";
    ea = addr & 'h1FFF;
    if (addr >= 'h2000) begin
      if (o >= 'h3C0 && m_mode == 1) begin
        tx = m_tidx % 32; ty = m_tidx / 32;
        sh = 2 * (((ty >> 1) & 1) * 2 + ((tx >> 1) & 1));
        ed = ((xr[m_tidx] >> 6) << sh) & 255; rq = "R5 ext attribute";
      end else if (s < 2) begin ed = exp_pg[s * 1024 + o]; rq = "R2 page read"; end
      else if (s == 2) begin ed = (m_mode >= 2) ? 0 : xr[o]; rq = "R4 ext tile read"; end
      else begin ed = (o >= 'h3C0) ? m_attr : m_tile; rq = "R3 fill read"; end
      if (o < 'h3C0) m_tidx = o;
    end else if (bg && m_mode == 1) begin
      eo = 1; ea = (m_hi << 18) | ((xr[m_tidx] & 63) << 12) | (addr & 'hFFF);
      rq = "R6 ext pattern bank";
    end
    @(negedge clk); req_valid = 1; req_we = 0; req_addr = addr[13:0]; req_bg = bg; rsp_ready = 0;
    @(negedge clk); req_valid = 0;
    e = ed;
    chk(rsp_valid && rsp_data == e[7:0] && rsp_pat_ovr == eo[0] && rsp_pat_addr == ea[19:0],
        rq, {rsp_pat_ovr, rsp_pat_addr, rsp_data}, {eo[0], ea[19:0], e[7:0]});
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_data == e[7:0], "R10 stall hold", rsp_data, e);
    end
    rsp_ready = 1;
    @(negedge clk); rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R10 taken", rsp_valid, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) begin pg[i] = $urandom % 256; exp_pg[i] = pg[i]; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R1 reset handshake", rsp_valid, 0);
    ren_rd('h2C05, 1, 0);           // R1: mapping reset to page A in every quadrant
    cpu_rd(7);                      // R1: mode 0 masks reads
    for (int i = 0; i < 1024; i++) cpu_wr(i, $urandom % 256);
    // R2/R3/R4 quadrants: q0 A, q1 B, q2 ext, q3 fill
    cfg(1, 8'b11_10_01_00);
    cfg(2, 8'h3A); cfg(3, 8'hFE);
    ren_rd('h2010, 0, 1); ren_rd('h2410, 0, 2); ren_rd('h2823, 0, 0);
    ren_rd('h2C00, 0, 0); ren_rd('h2FC0, 0, 0); ren_rd('h2FFF, 0, 3);
    cfg(3, 1); ren_rd('h3FC1, 0, 0);  // R3 replicated 0x55, bit 12 mirror
    // R8 fill writes discarded, page/ext writes land
    ren_wr('h2C44, 8'h99); ren_wr('h2044, 8'h11); ren_wr('h2444, 8'h22); ren_wr('h2844, 8'h33);
    cfg(1, 8'b00_10_01_00); ren_rd('h2C44, 0, 0); ren_rd('h2044, 0, 0);
    ren_rd('h2444, 0, 0); ren_rd('h2844, 0, 0);
    // R4/R9 mode 2 and 3
    cfg(0, 2); ren_rd('h2844, 0, 0); cpu_rd(8'h44);
    cfg(0, 3); cpu_wr(5, 8'hC3); cpu_rd(5);
    ren_wr('h2805, 8'h5A); cpu_rd(5);  // R8 renderer write in mode 3
    // R5/R6/R7/R11 extended mode
    cfg(0, 1); cfg(4, 2);
    cpu_wr(8'h62, 8'hC7);
    ren_rd('h2062, 0, 0); ren_rd('h23C8, 0, 0); ren_rd('h0ABC, 1, 1);
    ren_rd('h1ABC, 0, 0);            // R7 sprite phase
    ren_wr('h2001, 8'h77);           // R11 write does not latch
    ren_rd('h27D0, 0, 0); ren_rd('h1234, 1, 0);  // R11 index kept
    cpu_rd(3);
    for (int n = 0; n < 500; n++) begin
      int op = $urandom % 10, a = $urandom % 16384;
      case (op)
        0: cfg($urandom % 5, $urandom % 256);
        1: cpu_wr($urandom % 1024, $urandom % 256);
        2: cpu_rd($urandom % 1024);
        3: if (a >= 'h2000) ren_wr(a, $urandom % 256);
        default: ren_rd(a, $urandom % 2, $urandom % 3);
      endcase
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule